// File: doc/BRIEF.md
# Tamper Security Monitor

The block watches ten digital tamper and counter-overflow event lines. It keeps a sticky status bit for each line. When a line is enabled in the tamper configuration register and fires, the block sets a security-violation (failure) flag. While that flag is set, a freeze output holds the real-time counter, so the counter keeps the time of the event. A separate non-valid flag marks that stored state cannot be trusted. The low-power (battery) reset always sets this flag.

Two reset types act on the block.
- The asynchronous low-power reset `rst_ni` clears every lock and every register.
- The synchronous system reset `sys_rst_i` clears only the soft lock. It also moves a failed unit into the combined non-valid-plus-failure condition, unless the failure hard lock is set.

Software recovers from the combined condition with register writes, in this order:
1. Disable the sources.
2. Clear the event status bits (write one to clear).
3. Clear the failure flag.
4. Clear the non-valid flag last.

Top module: `tamper_monitor`

Write select codes on `wr_sel_i`: 0 = tamper configuration, 1 = control (locks), 2 = status (write one to clear), 3 = interrupt enable.

## Requirements
- R1: After the low-power reset, `status_o` reads 0x00000002 (only the non-valid flag, bit 1). `cfg_o` reads 0, `ctrl_o` reads 0, and `freeze_o` and `sv_irq_o` are low.
- R2: Event line k sets its status bit whether or not it is enabled.
  - Lines 0..7 map to status bits 16..23.
  - Line 8 (time-counter overflow) maps to status bit 2.
  - Line 9 (monotonic overflow) maps to status bit 3.
  - A line whose configuration bit k is clear never sets the failure flag.
- R3: A pulse on event line k while configuration bit k is set sets the failure flag (status bit 0) and `freeze_o` at the next clock edge.
- R4: Writing 1 to an event status bit through select 2 clears that bit, except when its event line is asserted in the same cycle. In that case the bit stays set.
- R5: Writes to the configuration register are ignored while control bit 29 (soft lock) or bit 30 (hard lock) is set. Lock bits in the control register can be set by a write but never cleared by one.
- R6: The system reset clears control bit 29 and leaves bits 30 and 16 unchanged. Only the low-power reset clears bits 30 and 16.
- R7: A system reset while the failure flag is set sets the non-valid flag, unless control bit 16 (failure hard lock) is set. In that case the status is unchanged.
- R8: Writing 1 to status bit 0 clears the failure flag only when the non-valid flag is set and no enabled event status bit remains set after the same write.
- R9: Writing 1 to status bit 1 clears the non-valid flag only while the failure flag is clear. With both flags clear, status reads the valid condition.
- R10: `sv_irq_o` is high exactly when the failure flag and interrupt-enable bit 0 are both set. The system reset clears the interrupt enable.
- R11: When an enabled event and a failure-flag clear arrive in the same cycle, the failure flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low low-power reset |
| sys_rst_i | input | 1 | Synchronous system reset, high for one or more cycles |
| event_i | input | 10 | Tamper/overflow event lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for the write |
| wr_data_i | input | 32 | Write data |
| status_o | output | 32 | Status word: flags and event bits |
| cfg_o | output | 10 | Tamper source enables |
| ctrl_o | output | 32 | Lock bits at positions 30, 29, 16 |
| freeze_o | output | 1 | Holds the real-time counter during failure |
| sv_irq_o | output | 1 | Security-violation interrupt |

## Verification
The bench walks event patterns against source enables, including disabled events that must only flag status. It covers the two overflow lines that sit apart from the main event group; a wrong bit map would misplace them.

The recovery order is attacked step by step:
- Clearing the non-valid flag during failure must do nothing.
- Clearing the failure flag must do nothing when the non-valid flag is clear or when an enabled event bit is still pending.

Done out of order, the unit would return to valid while tamper evidence remains.

The bench also checks the two reset types against each lock. It covers a status clear racing a held event line, and an enabled event racing a failure-flag clear. A design that let either clear win would lose evidence.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  localparam int N_EVT  = 10;
  localparam int DATA_W = 32;

  localparam int ST_SVF = 0;
  localparam int ST_NVF = 1;

  localparam int LK_CFG_HARD  = 30;
  localparam int LK_CFG_SOFT  = 29;
  localparam int LK_FAIL_HARD = 16;

  typedef enum logic [1:0] {
    SEL_CFG = 2'd0,
    SEL_CTL = 2'd1,
    SEL_STS = 2'd2,
    SEL_IEN = 2'd3
  } wr_sel_e;

  // status bit position of event line k
  function automatic int evt_pos(input int k);
    if (k < 8)       return 16 + k;
    else if (k == 8) return 2;
    else             return 3;
  endfunction
endpackage

// File: rtl/tmon_evt_bank.sv
module tmon_evt_bank #(
  parameter int N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_q_o,
  output logic [N-1:0] sts_d_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    logic bit_q;
    // a live event overrides the clear
    assign sts_d_o[k] = (bit_q & ~clr_i[k]) | evt_i[k];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= sts_d_o[k];
    end
    assign sts_q_o[k] = bit_q;
  end
endmodule

// File: rtl/tmon_cfg_lock.sv
module tmon_cfg_lock
  import tmon_pkg::*;
#(
  parameter int N = N_EVT,
  parameter int W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sys_rst_i,
  input  logic         cfg_we_i,
  input  logic         ctl_we_i,
  input  logic [W-1:0] data_i,
  output logic [N-1:0] cfg_o,
  output logic         cfg_hard_o,
  output logic         cfg_soft_o,
  output logic         fail_hard_o
);
  logic [N-1:0] cfg_q;
  logic         hard_q, soft_q, fhard_q;
  logic         locked;

  assign locked = hard_q | soft_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      hard_q  <= 1'b0;
      soft_q  <= 1'b0;
      fhard_q <= 1'b0;
    end else if (sys_rst_i) begin
      soft_q <= 1'b0;
    end else begin
      if (cfg_we_i && !locked) cfg_q <= data_i[N-1:0];
      if (ctl_we_i) begin
        hard_q  <= hard_q  | data_i[LK_CFG_HARD];
        soft_q  <= soft_q  | data_i[LK_CFG_SOFT];
        fhard_q <= fhard_q | data_i[LK_FAIL_HARD];
      end
    end
  end

  assign cfg_o       = cfg_q;
  assign cfg_hard_o  = hard_q;
  assign cfg_soft_o  = soft_q;
  assign fail_hard_o = fhard_q;
endmodule

// File: rtl/tmon_sec_fsm.sv
module tmon_sec_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_i,
  input  logic hit_i,
  input  logic pend_i,
  input  logic fail_hard_i,
  input  logic clr_svf_i,
  input  logic clr_nvf_i,
  output logic svf_o,
  output logic nvf_o
);
  logic svf_q, nvf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svf_q <= 1'b0;
      nvf_q <= 1'b1;
    end else begin
      if (hit_i)                              svf_q <= 1'b1;
      else if (clr_svf_i && nvf_q && !pend_i) svf_q <= 1'b0;

      if (sys_rst_i) begin
        if (svf_q && !fail_hard_i) nvf_q <= 1'b1;
      end else if (clr_nvf_i && !svf_q) begin
        nvf_q <= 1'b0;
      end
    end
  end

  assign svf_o = svf_q;
  assign nvf_o = nvf_q;
endmodule

// File: rtl/tamper_monitor.sv
module tamper_monitor
  import tmon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_i,
  input  logic [N_EVT-1:0]  event_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] status_o,
  output logic [N_EVT-1:0]  cfg_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              freeze_o,
  output logic              sv_irq_o
);
  logic             we;
  logic             we_cfg, we_ctl, we_sts, we_ien;
  logic [N_EVT-1:0] clr_mask, sts_q, sts_d, cfg;
  logic             cfg_hard, cfg_soft, fail_hard;
  logic             svf, nvf, ien_q;
  logic             hit, pend;

  assign we     = wr_en_i & ~sys_rst_i;
  assign we_cfg = we & (wr_sel_e'(wr_sel_i) == SEL_CFG);
  assign we_ctl = we & (wr_sel_e'(wr_sel_i) == SEL_CTL);
  assign we_sts = we & (wr_sel_e'(wr_sel_i) == SEL_STS);
  assign we_ien = we & (wr_sel_e'(wr_sel_i) == SEL_IEN);

  always_comb begin
    for (int k = 0; k < N_EVT; k++) clr_mask[k] = we_sts & wr_data_i[evt_pos(k)];
  end

  tmon_evt_bank #(.N(N_EVT)) u_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (event_i),
    .clr_i   (clr_mask),
    .sts_q_o (sts_q),
    .sts_d_o (sts_d)
  );

  tmon_cfg_lock #(.N(N_EVT), .W(DATA_W)) u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sys_rst_i   (sys_rst_i),
    .cfg_we_i    (we_cfg),
    .ctl_we_i    (we_ctl),
    .data_i      (wr_data_i),
    .cfg_o       (cfg),
    .cfg_hard_o  (cfg_hard),
    .cfg_soft_o  (cfg_soft),
    .fail_hard_o (fail_hard)
  );

  assign hit  = |(event_i & cfg);
  assign pend = |(sts_d & cfg);

  tmon_sec_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sys_rst_i   (sys_rst_i),
    .hit_i       (hit),
    .pend_i      (pend),
    .fail_hard_i (fail_hard),
    .clr_svf_i   (we_sts & wr_data_i[ST_SVF]),
    .clr_nvf_i   (we_sts & wr_data_i[ST_NVF]),
    .svf_o       (svf),
    .nvf_o       (nvf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ien_q <= 1'b0;
    else if (sys_rst_i) ien_q <= 1'b0;
    else if (we_ien)    ien_q <= wr_data_i[0];
  end

  always_comb begin
    status_o = '0;
    for (int k = 0; k < N_EVT; k++) status_o[evt_pos(k)] = sts_q[k];
    status_o[ST_SVF] = svf;
    status_o[ST_NVF] = nvf;
  end

  always_comb begin
    ctrl_o = '0;
    ctrl_o[LK_CFG_HARD]  = cfg_hard;
    ctrl_o[LK_CFG_SOFT]  = cfg_soft;
    ctrl_o[LK_FAIL_HARD] = fail_hard;
  end

  assign cfg_o    = cfg;
  assign freeze_o = svf;
  assign sv_irq_o = svf & ien_q;
endmodule

// File: rtl/tamper_monitor_chk.sv
module tamper_monitor_chk
  import tmon_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sys_rst_i,
  input logic [N_EVT-1:0]  event_i,
  input logic [DATA_W-1:0] status_o,
  input logic [N_EVT-1:0]  cfg_o,
  input logic [DATA_W-1:0] ctrl_o,
  input logic              sv_irq_o
);
  p_enabled_event_fails_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(event_i & cfg_o)) |=> status_o[ST_SVF]);

  p_cfg_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[LK_CFG_HARD] | ctrl_o[LK_CFG_SOFT]) |=> $stable(cfg_o));

  p_hard_lock_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[LK_CFG_HARD] && ctrl_o[LK_FAIL_HARD]) |=> (ctrl_o[LK_CFG_HARD] && ctrl_o[LK_FAIL_HARD]));

  p_svf_clear_needs_nvf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[ST_SVF]) |-> $past(status_o[ST_NVF]));

  p_nvf_clear_needs_no_svf_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[ST_NVF]) |-> !$past(status_o[ST_SVF]));

  p_irq_needs_svf_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[ST_SVF] |-> !sv_irq_o);

  p_sysrst_keeps_svf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_i && status_o[ST_SVF]) |=> status_o[ST_SVF]);
endmodule

bind tamper_monitor tamper_monitor_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sys_rst_i (sys_rst_i),
  .event_i   (event_i),
  .status_o  (status_o),
  .cfg_o     (cfg_o),
  .ctrl_o    (ctrl_o),
  .sv_irq_o  (sv_irq_o)
);

// File: tb/tamper_monitor_tb.sv
module tamper_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sys_rst_i = 1'b0;
  logic [9:0]  event_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] status_o, ctrl_o;
  logic [9:0]  cfg_o;
  logic        freeze_o, sv_irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tamper_monitor u_dut (
    .clk_i, .rst_ni, .sys_rst_i, .event_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .status_o, .cfg_o, .ctrl_o, .freeze_o, .sv_irq_o
  );

  // {event, cfg, expected status}
  localparam logic [51:0] VEC [NVEC] = '{
    {10'h001, 10'h000, 32'h0001_0002},
    {10'h001, 10'h001, 32'h0001_0003},
    {10'h100, 10'h100, 32'h0000_0007},
    {10'h200, 10'h000, 32'h0000_000A},
    {10'h080, 10'h07F, 32'h0080_0002},
    {10'h0A5, 10'h004, 32'h00A5_0003}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic lp_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic sys_reset();
    @(negedge clk_i); sys_rst_i = 1'b1;
    @(negedge clk_i); sys_rst_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic pulse(input logic [9:0] e);
    @(negedge clk_i); event_i = e;
    @(negedge clk_i); event_i = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    lp_reset();
    chk("R1 status", status_o, 32'h2);
    chk("R1 cfg", {22'd0, cfg_o}, 32'h0);
    chk("R1 ctrl", ctrl_o, 32'h0);
    chk("R1 freeze/irq", {30'd0, freeze_o, sv_irq_o}, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      lp_reset();
      wr(2'd0, {22'd0, VEC[v][41:32]});
      pulse(VEC[v][51:42]);
      chk("R2/R3 vector status", status_o, VEC[v][31:0]);
      chk("R3 vector freeze", {31'd0, freeze_o}, {31'd0, VEC[v][0]});
    end

    // R4: held event survives clear
    lp_reset();
    @(negedge clk_i); event_i = 10'h002;
    wr(2'd2, 32'h0002_0000);
    chk("R4 held event", status_o, 32'h0002_0002);
    event_i = '0;
    wr(2'd2, 32'h0002_0000);
    chk("R4 cleared", status_o, 32'h2);

    // R5: locks
    wr(2'd0, 32'h3FF);
    chk("R5 cfg open", {22'd0, cfg_o}, 32'h3FF);
    wr(2'd1, 32'h2000_0000);
    wr(2'd0, 32'h0);
    chk("R5 cfg soft locked", {22'd0, cfg_o}, 32'h3FF);
    wr(2'd1, 32'h0);
    chk("R5 lock set-only", ctrl_o, 32'h2000_0000);

    // R6: reset types vs locks
    sys_reset();
    chk("R6 soft cleared", ctrl_o, 32'h0);
    wr(2'd0, 32'h000);
    wr(2'd1, 32'h4001_0000);
    sys_reset();
    chk("R6 hard kept", ctrl_o, 32'h4001_0000);
    wr(2'd0, 32'h3FF);
    chk("R5 cfg hard locked", {22'd0, cfg_o}, 32'h0);
    lp_reset();
    chk("R6 lp clears hard", ctrl_o, 32'h0);

    // full recovery
    wr(2'd2, 32'h2);
    chk("R9 nvf clear to valid", status_o, 32'h0);
    wr(2'd3, 32'h1);
    wr(2'd0, 32'h001);
    pulse(10'h001);
    chk("R3 failure", status_o, 32'h0001_0001);
    chk("R10 irq on", {31'd0, sv_irq_o}, 32'h1);
    wr(2'd2, 32'h1);
    chk("R8 svf kept without nvf", status_o, 32'h0001_0001);
    sys_reset();
    chk("R7 sysrst to nvf+fail", status_o, 32'h0001_0003);
    chk("R10 irq off after sysrst", {31'd0, sv_irq_o}, 32'h0);
    wr(2'd2, 32'h2);
    chk("R9 nvf kept during fail", status_o, 32'h0001_0003);
    wr(2'd2, 32'h1);
    chk("R8 svf kept while pending", status_o, 32'h0001_0003);
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h0001_0000);
    chk("R4 evt cleared", status_o, 32'h3);
    wr(2'd2, 32'h1);
    chk("R8 svf cleared", status_o, 32'h2);
    wr(2'd2, 32'h2);
    chk("R9 valid", status_o, 32'h0);
    chk("R3 freeze released", {31'd0, freeze_o}, 32'h0);

    // R7: failure hard lock blocks sysrst path
    lp_reset();
    wr(2'd2, 32'h2);
    wr(2'd1, 32'h0001_0000);
    wr(2'd0, 32'h001);
    pulse(10'h001);
    sys_reset();
    chk("R7 fail hard lock", status_o, 32'h0001_0001);
    chk("R6 fail hard kept", ctrl_o, 32'h0001_0000);

    // R11: enabled event races svf clear
    lp_reset();
    wr(2'd0, 32'h002);
    pulse(10'h002);
    wr(2'd2, 32'h0002_0000);
    chk("R11 setup", status_o, 32'h3);
    @(negedge clk_i); event_i = 10'h002; wr_en_i = 1'b1; wr_sel_i = 2'd2; wr_data_i = 32'h1;
    @(negedge clk_i); event_i = '0; wr_en_i = 1'b0;
    chk("R11 event wins", status_o, 32'h0002_0003);
    wr(2'd2, 32'h0002_0001);
    chk("R8 same-write clear", status_o, 32'h2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule